// File: doc/BRIEF.md
# Sector Write Sequencer

This block times the serial write of one disk sector. Once an operation is armed with a word count, the next sector mark starts a fixed sequence of fields. All fields are counted in bit-clock enables. The sync field turns the write gate on part way through and writes zeros. It ends with a single one that marks where the data starts. The data field writes 96 sixteen-bit words, most significant bit first. The checkword field passes twelve bits from an external checkword generator to the output, then closes the gate and returns to idle.

Words are fetched ahead of time through a two-entry buffer, using a request/acknowledge pair toward memory. Two fetches are made during the sync field. After that, one fetch is made each time a word moves into the shift register. Fetches stop two words before the end of the sector, so no word is fetched that the sector cannot hold. A length counter drops by one for each acknowledged word. When it reaches zero, no more fetches are made and the rest of the sector is padded with zeros. If the shift register needs a word, no word is buffered and the length is not yet used up, the word is written as zeros and a sticky lost-data flag is raised. In both cases the operation ends with the current sector. Checkword arithmetic and address stepping are handled outside this block.

Top module: `sector_write_seq`

## Requirements
- R1: While reset is asserted and after it is released, write gate, serial data, memory request, busy and lost-data are all 0.
- R2: A pulse on op_start loads op_len (a count of words), sets busy and clears lost-data. A sector mark while busy is 0 is ignored: the gate stays 0 and no fetch is made.
- R3: Bit ticks are numbered from 0, starting with the first bit enable after an accepted sector mark. The write gate is 0 for ticks 0 to 119 and 1 from tick 120 up to the end of the data field. Serial data is 0 for ticks 0 to 231 and 1 at tick 232.
- R4: No word is acknowledged before tick 120 of the sector. When the length allows it, exactly two words are fetched by tick 232.
- R5: Ticks 233 to 1768 carry 96 words, each 16 bits with the most significant bit first, in the order the words were acknowledged.
- R6: No fetch occurs once word 94 of a sector (counting from 0) has started. A sector fetches at most 96 words.
- R7: The length drops by one for each acknowledged word, and no fetch is made at length 0. Words left over in the sector are written as zeros. Busy falls at the end of the sector in which the length reached 0.
- R8: If a word is needed, none is buffered and the length is non-zero, lost-data is set and the word is written as zeros. Busy falls at the end of that sector. Lost-data stays set until the next op_start.
- R9: Checkword ticks c = 0 to 11 (tick 1769 + c) copy ckw_bit to serial data, with ckw_shift at 1. For c of 12 and above, data and ckw_shift are 0. The gate is 1 for c below 15 and 0 from c = 15.
- R10: sector_done is 1 exactly at checkword tick 36, after which the block is idle and waits for the next sector mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Arms an operation and loads op_len |
| op_len | input | 16 | Number of words to write |
| sector_mark | input | 1 | Start-of-sector pulse |
| bit_en | input | 1 | One-cycle enable per serial bit time |
| mem_req | output | 1 | Word fetch request |
| mem_ack | input | 1 | Fetch acknowledge, mem_data valid |
| mem_data | input | 16 | Fetched word |
| ckw_bit | input | 1 | Next checkword bit from the external generator |
| ckw_shift | output | 1 | Checkword bit is being written this tick |
| wr_gate | output | 1 | Write gate to the head |
| wr_data | output | 1 | Serial write data |
| busy | output | 1 | Operation armed |
| lost_data | output | 1 | Sticky underrun flag |
| sector_done | output | 1 | Strobe at the last tick of a sector |

## Verification
The bench writes sectors under four stimulus patterns, and each one isolates a different part of the behaviour. The first is a sector mark with no operation armed, which shows that the arming gate works. The second is a length longer than one sector, so the first sector is full and the second is partly data and partly zero padding. This exposes errors in the per-sector fetch limit, the length countdown and the ordering of the two-entry buffer. The third withholds every acknowledge, so an underrun cannot be mistaken for ordinary padding, and it checks that the lost flag survives a later sector mark. The fourth uses a length of zero, which should produce a full-zero sector with no fetch at all. In every sector, the gate, the data bit and the checkword pass-through are compared at each bit tick against positions computed from the field boundaries.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2,
    ST_CKW  = 2'd3
  } swr_state_e;
endpackage

// File: rtl/swr_fsm.sv
`timescale 1ns/1ps
module swr_fsm import swr_pkg::*; #(
  parameter int W            = 16,
  parameter int SYNC_GATE    = 120,
  parameter int SYNC_BIT     = 232,
  parameter int WORDS        = 96,
  parameter int CKW_BITS     = 12,
  parameter int CKW_GATE_OFF = 15,
  parameter int CKW_END      = 36,
  localparam int FCW = $clog2(SYNC_BIT + 1),
  localparam int WCW = $clog2(WORDS),
  localparam int BCW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           sector_mark,
  input  logic           bit_en,
  output swr_state_e     state_o,
  output logic           prime_o,
  output logic           load_o,
  output logic [WCW-1:0] load_idx_o,
  output logic           shift_o,
  output logic           end_o,
  output logic           gate_o,
  output logic           sync_bit_o,
  output logic           ckw_win_o
);
  swr_state_e     state, n_state;
  logic [FCW-1:0] fcnt, n_fcnt;
  logic [BCW-1:0] bcnt, n_bcnt;
  logic [WCW-1:0] wcnt, n_wcnt;

  logic last_bit, last_word;
  assign last_bit  = (bcnt == BCW'(W - 1));
  assign last_word = (wcnt == WCW'(WORDS - 1));

  always_comb begin
    n_state = state;
    n_fcnt  = fcnt;
    n_bcnt  = bcnt;
    n_wcnt  = wcnt;
    case (state)
      ST_IDLE: if (active && sector_mark) begin
        n_state = ST_SYNC;
        n_fcnt  = '0;
      end
      ST_SYNC: if (bit_en) begin
        if (fcnt == FCW'(SYNC_BIT)) begin
          n_state = ST_DATA;
          n_bcnt  = '0;
          n_wcnt  = '0;
        end else begin
          n_fcnt = fcnt + 1'b1;
        end
      end
      ST_DATA: if (bit_en) begin
        if (last_bit) begin
          n_bcnt = '0;
          if (last_word) begin
            n_state = ST_CKW;
            n_fcnt  = '0;
          end else begin
            n_wcnt = wcnt + 1'b1;
          end
        end else begin
          n_bcnt = bcnt + 1'b1;
        end
      end
      default: if (bit_en) begin
        if (fcnt == FCW'(CKW_END)) n_state = ST_IDLE;
        else                       n_fcnt  = fcnt + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      fcnt  <= '0;
      bcnt  <= '0;
      wcnt  <= '0;
    end else begin
      state <= n_state;
      fcnt  <= n_fcnt;
      bcnt  <= n_bcnt;
      wcnt  <= n_wcnt;
    end
  end

  assign state_o    = state;
  assign sync_bit_o = (state == ST_SYNC) && (fcnt == FCW'(SYNC_BIT));
  assign prime_o    = (state == ST_SYNC) && bit_en && (fcnt == FCW'(SYNC_GATE));
  assign load_o     = bit_en && (sync_bit_o ||
                      ((state == ST_DATA) && last_bit && !last_word));
  assign load_idx_o = (state == ST_SYNC) ? '0 : wcnt + 1'b1;
  assign shift_o    = (state == ST_DATA) && bit_en && !last_bit;
  assign end_o      = (state == ST_CKW) && bit_en && (fcnt == FCW'(CKW_END));
  assign ckw_win_o  = (state == ST_CKW) && (fcnt < FCW'(CKW_BITS));
  assign gate_o     = ((state == ST_SYNC) && (fcnt >= FCW'(SYNC_GATE))) ||
                      (state == ST_DATA) ||
                      ((state == ST_CKW) && (fcnt < FCW'(CKW_GATE_OFF)));

  // R2: no sector can start while nothing is armed
  p_mark_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !active) |=> (state == ST_IDLE));
  // R3: an accepted mark opens the sync field with a cleared count
  p_sync_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && active && sector_mark) |=> (state == ST_SYNC && fcnt == '0));
  // R10: the closing strobe returns the sequencer to idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (state == ST_IDLE));
endmodule

// File: rtl/swr_prefetch.sv
`timescale 1ns/1ps
module swr_prefetch #(
  parameter int W        = 16,
  parameter int LW       = 16,
  parameter int WORDS    = 96,
  parameter int PREFETCH = 2,
  localparam int WCW      = $clog2(WORDS),
  localparam int NW       = $clog2(PREFETCH + 1),
  localparam int REQ_LAST = WORDS - PREFETCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_start,
  input  logic [LW-1:0]  op_len,
  input  logic           mem_ack,
  input  logic [W-1:0]   mem_data,
  input  logic           prime,
  input  logic           load,
  input  logic [WCW-1:0] load_idx,
  input  logic           sector_end,
  output logic           mem_req,
  output logic [W-1:0]   word_o,
  output logic           active_o,
  output logic           lost_o
);
  logic [W-1:0]  b1, b2, n_b1, n_b2;
  logic          v1, v2, n_v1, n_v2;
  logic [NW-1:0] need, n_need;
  logic [LW-1:0] len, n_len;
  logic          lost, n_lost, active, n_active;
  logic          ack, starve, req_more;

  assign ack      = mem_req && mem_ack;
  assign starve   = load && !v2 && !v1;
  assign req_more = load && (load_idx < WCW'(REQ_LAST));
  assign word_o   = v2 ? b2 : (v1 ? b1 : '0);
  assign mem_req  = active && (need != '0) && (len != '0);

  always_comb begin
    n_b1 = b1; n_b2 = b2; n_v1 = v1; n_v2 = v2;
    n_len    = len - {{(LW-1){1'b0}}, ack};
    n_need   = need + {{(NW-1){1'b0}}, req_more} - {{(NW-1){1'b0}}, ack};
    n_lost   = lost || (starve && (len != '0));
    n_active = active;
    if (prime) n_need = NW'(PREFETCH);
    // consume the oldest word
    if (load) begin
      if (v2)      n_v2 = 1'b0;
      else if (v1) n_v1 = 1'b0;
    end
    // age the younger entry
    if (n_v1 && !n_v2) begin
      n_b2 = b1;
      n_v2 = 1'b1;
      n_v1 = 1'b0;
    end
    if (ack) begin
      n_b1 = mem_data;
      n_v1 = 1'b1;
    end
    if (sector_end) begin
      n_need = '0;
      n_v1   = 1'b0;
      n_v2   = 1'b0;
      if (n_len == '0 || n_lost) n_active = 1'b0;
    end
    if (op_start) begin
      n_len    = op_len;
      n_lost   = 1'b0;
      n_active = 1'b1;
      n_need   = '0;
      n_v1     = 1'b0;
      n_v2     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= '0; b2 <= '0; v1 <= 1'b0; v2 <= 1'b0;
      need <= '0; len <= '0; lost <= 1'b0; active <= 1'b0;
    end else begin
      b1 <= n_b1; b2 <= n_b2; v1 <= n_v1; v2 <= n_v2;
      need <= n_need; len <= n_len; lost <= n_lost; active <= n_active;
    end
  end

  assign active_o = active;
  assign lost_o   = lost;

  // R5: an arriving word always finds a free entry
  p_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |-> !(v1 && v2));
  // R7: each accepted word takes one from the length
  p_len_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !op_start) |=> (len == $past(len) - 1'b1));
  // R8: the underrun flag is held until re-armed
  p_lost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !op_start) |=> lost);
endmodule

// File: rtl/swr_shifter.sv
`timescale 1ns/1ps
module swr_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word,
  output logic         msb
);
  logic [W-1:0] sh, n_sh;

  always_comb begin
    n_sh = sh;
    if (load)       n_sh = word;
    else if (shift) n_sh = {sh[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= n_sh;
  end

  assign msb = sh[W-1];

  // R5: bits leave from the top, one per tick
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sh == {$past(sh[W-2:0]), 1'b0}));
endmodule

// File: rtl/sector_write_seq.sv
`timescale 1ns/1ps
module sector_write_seq import swr_pkg::*; #(
  parameter int W            = 16,
  parameter int LW           = 16,
  parameter int SYNC_GATE    = 120,
  parameter int SYNC_BIT     = 232,
  parameter int WORDS        = 96,
  parameter int PREFETCH     = 2,
  parameter int CKW_BITS     = 12,
  parameter int CKW_GATE_OFF = 15,
  parameter int CKW_END      = 36,
  localparam int WCW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [LW-1:0] op_len,
  input  logic          sector_mark,
  input  logic          bit_en,
  output logic          mem_req,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_data,
  input  logic          ckw_bit,
  output logic          ckw_shift,
  output logic          wr_gate,
  output logic          wr_data,
  output logic          busy,
  output logic          lost_data,
  output logic          sector_done
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  swr_state_e     state;
  logic           prime, load, shift, sec_end, gate, sync_bit, ckw_win;
  logic           active, lost, msb;
  logic [WCW-1:0] load_idx;
  logic [W-1:0]   next_word;

  swr_fsm #(
    .W(W), .SYNC_GATE(SYNC_GATE), .SYNC_BIT(SYNC_BIT), .WORDS(WORDS),
    .CKW_BITS(CKW_BITS), .CKW_GATE_OFF(CKW_GATE_OFF), .CKW_END(CKW_END)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sn), .active(active), .sector_mark(sector_mark),
    .bit_en(bit_en), .state_o(state), .prime_o(prime), .load_o(load),
    .load_idx_o(load_idx), .shift_o(shift), .end_o(sec_end), .gate_o(gate),
    .sync_bit_o(sync_bit), .ckw_win_o(ckw_win)
  );

  swr_prefetch #(
    .W(W), .LW(LW), .WORDS(WORDS), .PREFETCH(PREFETCH)
  ) u_prefetch (
    .clk(clk), .rst_n(rst_sn), .op_start(op_start), .op_len(op_len),
    .mem_ack(mem_ack), .mem_data(mem_data), .prime(prime), .load(load),
    .load_idx(load_idx), .sector_end(sec_end), .mem_req(mem_req),
    .word_o(next_word), .active_o(active), .lost_o(lost)
  );

  swr_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_sn), .load(load), .shift(shift),
    .word(next_word), .msb(msb)
  );

  assign wr_gate     = gate;
  assign wr_data     = sync_bit || ((state == ST_DATA) && msb) || (ckw_win && ckw_bit);
  assign ckw_shift   = ckw_win;
  assign busy        = active;
  assign lost_data   = lost;
  assign sector_done = sec_end;

  // R1: no write activity while held in reset
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_sn |-> (!wr_gate && !mem_req && !busy));
endmodule

// File: tb/tb_sector_write_seq.sv
`timescale 1ns/1ps
module tb_sector_write_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [15:0] op_len = '0;
  logic        sector_mark = 1'b0;
  logic        bit_en = 1'b0;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_data = '0;
  logic        ckw_bit = 1'b0;
  logic        ckw_shift, wr_gate, wr_data, busy, lost_data, sector_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ack_cnt = 0;
  int seq = 0;
  bit stall = 1'b0;
  bit done_flag = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  sector_write_seq dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_len(op_len),
    .sector_mark(sector_mark), .bit_en(bit_en), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_data(mem_data), .ckw_bit(ckw_bit),
    .ckw_shift(ckw_shift), .wr_gate(wr_gate), .wr_data(wr_data),
    .busy(busy), .lost_data(lost_data), .sector_done(sector_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bit-time and checkword source
  always @(posedge clk) begin
    #1;
    cyc++;
    bit_en  = (cyc % 4 == 0);
    ckw_bit = cyc[3] ^ cyc[6];
  end

  // memory driver: pushes each word it hands over into the scoreboard
  always @(posedge clk) begin
    #1;
    if (mem_req && !mem_ack && !stall) begin
      seq++;
      mem_data = 16'h5A3C ^ 16'(seq * 16'h9E37);
      mem_ack  = 1'b1;
      ack_cnt++;
      exp_q.push_back(mem_data);
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic arm(input int len);
    @(posedge clk); #1; op_start = 1'b1; op_len = 16'(len);
    @(posedge clk); #1; op_start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after arm", busy, 1);
    chk(lost_data == 1'b0, "R2 lost cleared by arm", lost_data, 0);
  endtask

  // monitor: walks one sector tick by tick and pops expected words
  task automatic run_sector(input bit armed, input int sync_acks, input int tot_acks,
                            input bit exp_busy, input bit exp_lost, input string dtag);
    int base;
    int acks94;
    int ntick;
    logic [15:0] acc;
    logic [15:0] expw;
    acc = '0;
    acks94 = 0;
    @(posedge clk); #1; sector_mark = 1'b1;
    @(posedge clk); #1; sector_mark = 1'b0;
    base  = ack_cnt;
    ntick = armed ? 1806 : 240;
    for (int k = 0; k < ntick; k++) begin
      do @(negedge clk); while (!bit_en);
      if (!armed) begin
        chk(wr_gate == 1'b0, "R2 gate with mark ignored", wr_gate, 0);
        chk(mem_req == 1'b0, "R2 no fetch with mark ignored", mem_req, 0);
      end else if (k < 233) begin
        chk(wr_gate == (k >= 120), "R3 sync gate", wr_gate, (k >= 120));
        chk(wr_data == (k == 232), "R3 sync data", wr_data, (k == 232));
        if (k == 120) chk(ack_cnt - base == 0, "R4 no fetch before tick 120", ack_cnt - base, 0);
        if (k == 232) chk(ack_cnt - base == sync_acks, "R4 sync fetch count", ack_cnt - base, sync_acks);
      end else if (k < 1769) begin
        int d;
        d = k - 233;
        chk(wr_gate == 1'b1, "R3 data gate", wr_gate, 1);
        acc = {acc[14:0], wr_data};
        if (d == 94 * 16) acks94 = ack_cnt;
        if (d % 16 == 15) begin
          expw = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
          chk(acc == expw, dtag, acc, expw);
        end
      end else begin
        int c;
        c = k - 1769;
        chk(wr_gate == (c < 15), "R9 checkword gate", wr_gate, (c < 15));
        chk(ckw_shift == (c < 12), "R9 checkword strobe", ckw_shift, (c < 12));
        chk(wr_data == ((c < 12) ? ckw_bit : 1'b0), "R9 checkword data", wr_data,
            (c < 12) ? ckw_bit : 1'b0);
        chk(sector_done == (c == 36), "R10 sector done strobe", sector_done, (c == 36));
      end
    end
    if (armed) begin
      chk(ack_cnt == acks94, "R6 fetch after word 94", ack_cnt, acks94);
      chk(ack_cnt - base == tot_acks, "R6 words fetched in sector", ack_cnt - base, tot_acks);
      repeat (2) @(negedge clk);
      chk(wr_gate == 1'b0, "R10 idle after sector", wr_gate, 0);
    end
    @(negedge clk);
    chk(busy == exp_busy, "R7 busy after sector", busy, exp_busy);
    chk(lost_data == exp_lost, "R8 lost after sector", lost_data, exp_lost);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_gate == 1'b0, "R1 gate in reset", wr_gate, 0);
    chk(mem_req == 1'b0, "R1 req in reset", mem_req, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr_gate == 1'b0 && wr_data == 1'b0, "R1 outputs after reset", {wr_gate, wr_data}, 0);
    chk(lost_data == 1'b0 && mem_req == 1'b0, "R1 status after reset", {lost_data, mem_req}, 0);

    // mark with nothing armed
    run_sector(1'b0, 0, 0, 1'b0, 1'b0, "R2");

    // length spans two sectors: full sector then partial with padding
    arm(100);
    run_sector(1'b1, 2, 96, 1'b1, 1'b0, "R5 data word");
    run_sector(1'b1, 2, 4, 1'b0, 1'b0, "R7 data word with padding");
    chk(exp_q.size() == 0, "R7 every fetched word written", exp_q.size(), 0);

    // memory never answers: underrun
    stall = 1'b1;
    arm(5);
    run_sector(1'b1, 0, 0, 1'b0, 1'b1, "R8 zero word on underrun");
    stall = 1'b0;
    run_sector(1'b0, 0, 0, 1'b0, 1'b1, "R8");

    // zero length: all-zero sector, no fetch
    arm(0);
    run_sector(1'b1, 0, 0, 1'b0, 1'b0, "R7 zero length word");

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule